// File: doc/BRIEF.md
# Multiplexed-Bus Memory Read Controller

This block is the host side of a byte-wide read path to a 64K x 8 memory whose low address byte and data byte share one set of eight lines. A request carries a 16-bit address. The upper byte goes out on dedicated pins. The lower byte is driven onto the shared lines while an address-latch strobe is high, and the memory captures it when the strobe falls. The controller keeps driving for a hold interval, then releases the lines and pulls an active-low read enable. At the end of the access window it samples the returned byte and pulses a ready flag with the data.

Each timing interval is a parameter in system clock cycles, rounded up from the memory's nanosecond limits. The memory has no chip-enable pin. When the controller is idle it keeps the strobe and read enable high, so the memory sits in standby with its outputs floating. A busy flag holds off new requests until the memory has had time to stop driving the shared lines.

Top module: `mux_rd_ctrl`

## Requirements
- R1: While idle, `ale_o` is 1, `oe_no` is 1, `bus_oe_o` is 0 and `busy_o` is 0. This is also the state after reset.
- R2: A request is taken when `req_i` is 1 at a rising edge while `busy_o` is 0, and `busy_o` is 1 from the next cycle. A `req_i` pulse while `busy_o` is 1 is ignored and produces no read.
- R3: During a read, `hi_addr_o` carries request address bits 15:8 and `bus_o` carries bits 7:0. Both hold steady while the driver is enabled, so the memory latches the requested address.
- R4: Before the strobe falls, `ale_o` is 1 with the bus driver enabled for exactly SETUP_CYC + STROBE_CYC consecutive cycles.
- R5: After `ale_o` falls, the driver stays enabled for exactly HOLD_CYC cycles. It turns off in the same cycle that `oe_no` falls, and `ale_o` is 0 whenever `oe_no` is 0.
- R6: `oe_no` is 0 for exactly ACCESS_CYC consecutive cycles per read, and `bus_oe_o` is never 1 while `oe_no` is 0.
- R7: `bus_i` is sampled at the clock edge that ends the last `oe_no` low cycle. `ready_o` is then 1 for exactly one cycle with that byte on `data_o`, and `data_o` does not change at any other time.
- R8: After `oe_no` rises, the controller stays busy with the driver off, `ale_o` low and `oe_no` high for exactly FLOAT_CYC cycles. After that it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | 16 | Read address, sampled when the request is taken |
| busy_o | output | 1 | Read in progress; requests are ignored |
| ready_o | output | 1 | One-cycle flag: data_o holds the read byte |
| data_o | output | 8 | Last byte read |
| hi_addr_o | output | 8 | Upper address byte to the memory |
| bus_o | output | 8 | Value driven onto the shared lines (low address byte) |
| bus_i | input | 8 | Value seen on the shared lines |
| bus_oe_o | output | 1 | Enable of the controller's driver on the shared lines |
| ale_o | output | 1 | Address-latch strobe; memory latches on its falling edge |
| oe_no | output | 1 | Memory read enable, active low |

## Verification
The hardest case to reach is the shortest turnaround. In that case a new read starts right after the float interval, so an early drive of the bus would collide with the memory's last output. The bench reaches it by holding `req_i` high across two reads, which makes the second read start one cycle after the float ends. A memory model puts a junk byte on the bus until the read enable has been low for ACCESS_CYC cycles, so the bench sees any sample taken too early. It also pulses `req_i` in the middle of a read to show that the pulse starts no extra read.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_ACC,
    ST_FLT
  } rd_state_e;
endpackage

// File: rtl/mrc_timer.sv
module mrc_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/mrc_seq.sv
module mrc_seq
  import mrc_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int FLOAT_CYC  = 2,
  parameter int CNT_W      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             tmr_done_i,
  output rd_state_e        state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             capture_o
);
  rd_state_e state_q, state_d;

  function automatic logic [CNT_W-1:0] phase_len(rd_state_e s);
    case (s)
      ST_ADDR: phase_len = CNT_W'(SETUP_CYC - 1);
      ST_STRB: phase_len = CNT_W'(STROBE_CYC - 1);
      ST_HOLD: phase_len = CNT_W'(HOLD_CYC - 1);
      ST_ACC:  phase_len = CNT_W'(ACCESS_CYC - 1);
      ST_FLT:  phase_len = CNT_W'(FLOAT_CYC - 1);
      default: phase_len = '0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_i)      state_d = ST_ADDR;
      ST_ADDR: if (tmr_done_i) state_d = ST_STRB;
      ST_STRB: if (tmr_done_i) state_d = ST_HOLD;
      ST_HOLD: if (tmr_done_i) state_d = ST_ACC;
      ST_ACC:  if (tmr_done_i) state_d = ST_FLT;
      ST_FLT:  if (tmr_done_i) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o    = state_q;
  assign tmr_load_o = (state_d != state_q);
  assign tmr_val_o  = phase_len(state_d);
  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign capture_o  = (state_q == ST_ACC) && tmr_done_i;

  AST_ACC_TO_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACC && tmr_done_i) |=> (state_q == ST_FLT)); // R8
  AST_TAKE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_i) |=> (state_q == ST_ADDR)); // R2
endmodule

// File: rtl/mux_rd_ctrl.sv
module mux_rd_ctrl
  import mrc_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int ACCESS_CYC = 3,
  parameter int FLOAT_CYC  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [15:0] addr_i,
  output logic        busy_o,
  output logic        ready_o,
  output logic [7:0]  data_o,
  output logic [7:0]  hi_addr_o,
  output logic [7:0]  bus_o,
  input  logic [7:0]  bus_i,
  output logic        bus_oe_o,
  output logic        ale_o,
  output logic        oe_no
);
  localparam int MAX_A   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_B   = (HOLD_CYC > ACCESS_CYC) ? HOLD_CYC : ACCESS_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_AB > FLOAT_CYC) ? MAX_AB : FLOAT_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  rd_state_e        state;
  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;
  logic [15:0]      addr_q;
  logic [7:0]       data_q;
  logic             ready_q;

  mrc_seq #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .FLOAT_CYC (FLOAT_CYC),
    .CNT_W     (CNT_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .tmr_done_i(tmr_done),
    .state_o   (state),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .accept_o  (accept),
    .capture_o (capture)
  );

  mrc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= addr_i;
  end

  // sample point: last cycle of the read-enable window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= capture;
      if (capture) data_q <= bus_i;
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign ale_o     = (state == ST_IDLE) || (state == ST_ADDR) || (state == ST_STRB);
  assign bus_oe_o  = (state == ST_ADDR) || (state == ST_STRB) || (state == ST_HOLD);
  assign oe_no     = (state != ST_ACC);
  assign hi_addr_o = addr_q[15:8];
  assign bus_o     = addr_q[7:0];
  assign data_o    = data_q;
  assign ready_o   = ready_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ale_o && oe_no && !bus_oe_o)); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && $past(bus_oe_o)) |-> ($stable(bus_o) && $stable(hi_addr_o))); // R3
  AST_OE_ALE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !ale_o); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_oe_o && !oe_no)); // R6
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R7
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> $stable(data_o)); // R7
  AST_FLOAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_no) |-> (busy_o && !bus_oe_o && !ale_o)); // R8
endmodule

// File: tb/tb_mux_rd_ctrl.sv
module tb_mux_rd_ctrl;
  localparam int SETUP_CYC  = 1;
  localparam int STROBE_CYC = 3;
  localparam int HOLD_CYC   = 1;
  localparam int ACCESS_CYC = 3;
  localparam int FLOAT_CYC  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] addr = '0;
  logic        busy, ready, bus_oe, ale, oe_n;
  logic [7:0]  data, hi_addr, bus_out, bus_in;

  int n_chk = 0, n_fail = 0, n_ready = 0, n_push = 0, oe_cnt = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  mux_rd_ctrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC),
    .ACCESS_CYC(ACCESS_CYC), .FLOAT_CYC(FLOAT_CYC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .busy_o(busy), .ready_o(ready), .data_o(data), .hi_addr_o(hi_addr),
    .bus_o(bus_out), .bus_i(bus_in), .bus_oe_o(bus_oe), .ale_o(ale), .oe_no(oe_n)
  );

  function automatic logic [7:0] mem_f(logic [15:0] a);
    return a[7:0] ^ {a[3:0], a[15:12]} ^ 8'h5A;
  endfunction

  // memory model: valid data only after read enable has been low ACCESS_CYC cycles
  logic [15:0] lat_addr = '0;
  always @(negedge clk) oe_cnt <= oe_n ? 0 : oe_cnt + 1;
  assign bus_in = (!oe_n && oe_cnt >= ACCESS_CYC) ? mem_f(lat_addr) : 8'hEE;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit p_ale = 1, p_oe_n = 1, p_ready = 0, p_flt = 0, seen_read = 0;
  int c_ah = 0, c_hold = 0, c_acc = 0, c_flt = 0, c_gap = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit in_flt = busy && oe_n && !ale && !bus_oe;
      if (bus_oe && !oe_n) chk(0, "R6 contention", 1, 0);
      if (p_ale && !ale) begin
        chk(c_ah == SETUP_CYC + STROBE_CYC, "R4 strobe+setup cycles", c_ah, SETUP_CYC + STROBE_CYC);
        chk(bus_oe, "R5 driven at strobe fall", bus_oe, 1);
        lat_addr = {hi_addr, bus_out};
      end
      c_ah = (ale && bus_oe) ? c_ah + 1 : 0;
      if (p_oe_n && !oe_n) begin
        chk(c_hold == HOLD_CYC, "R5 hold cycles", c_hold, HOLD_CYC);
        chk(!bus_oe && !ale, "R5 released at read enable", {ale, bus_oe}, 0);
      end
      c_hold = (!ale && bus_oe) ? c_hold + 1 : 0;
      if (!p_oe_n && oe_n) chk(c_acc == ACCESS_CYC, "R6 read enable cycles", c_acc, ACCESS_CYC);
      c_acc = !oe_n ? c_acc + 1 : 0;
      if (p_flt && !in_flt) chk(c_flt == FLOAT_CYC, "R8 float cycles", c_flt, FLOAT_CYC);
      c_flt = in_flt ? c_flt + 1 : 0;
      if (bus_oe && seen_read && c_gap != 0) begin
        chk(c_gap > FLOAT_CYC, "R8 turnaround gap", c_gap, FLOAT_CYC + 1);
        c_gap = 0;
      end
      if (!p_oe_n && oe_n) begin seen_read = 1; c_gap = 0; end
      if (seen_read && !bus_oe && oe_n) c_gap++;
      if (ready && p_ready) chk(0, "R7 ready longer than one cycle", 2, 1);
      if (ready) begin
        n_ready++;
        if (exp_q.size() == 0) chk(0, "R2 unexpected read", 1, 0);
        else begin
          automatic logic [15:0] e = exp_q.pop_front();
          chk(data == mem_f(e), "R7 data", data, mem_f(e));
          chk(lat_addr == e, "R3 latched address", lat_addr, e);
        end
      end
      p_ale = ale; p_oe_n = oe_n; p_ready = ready; p_flt = in_flt;
    end
  end

  task automatic issue(input logic [15:0] a);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; addr = a; exp_q.push_back(a); n_push++;
    @(negedge clk);
    chk(busy, "R2 busy after request", busy, 1);
    req = 0; addr = 16'hFFFF ^ a;
  endtask

  task automatic poke_busy(input logic [15:0] a);
    @(negedge clk);
    chk(busy, "R2 busy before ignored request", busy, 1);
    req = 1; addr = a;
    @(negedge clk);
    req = 0;
  endtask

  task automatic issue_b2b(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; addr = a; exp_q.push_back(a); n_push++;
    @(negedge clk);
    addr = b; exp_q.push_back(b); n_push++;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(busy, "R2 held request taken after idle", busy, 1);
    req = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ale && oe_n && !bus_oe && !busy && !ready, "R1 reset state",
        {ale, oe_n, bus_oe, busy, ready}, 5'b11000);
    rst_n = 1;
    @(negedge clk);
    chk(ale && oe_n && !bus_oe && !busy, "R1 idle after reset", {ale, oe_n, bus_oe, busy}, 4'b1100);
    issue(16'h0000);
    issue(16'hFFFF);
    issue(16'h5555);
    issue(16'h2AAA);
    issue(16'h1234);
    poke_busy(16'hDEAD);
    issue(16'hA5C3);
    poke_busy(16'hBEEF);
    drain();
    chk(n_ready == n_push, "R2 ignored requests", n_ready, n_push);
    chk(ale && oe_n && !bus_oe && !busy, "R1 idle after reads", {ale, oe_n, bus_oe, busy}, 4'b1100);
    issue_b2b(16'h00FF, 16'hFF00);
    issue_b2b(16'h8001, 16'h7FFE);
    for (int i = 0; i < 6; i++) issue(16'(i * 16'h2F17 + 16'h0101));
    drain();
    chk(n_ready == n_push, "R7 one ready per read", n_ready, n_push);
    chk(ale && oe_n && !bus_oe && !busy, "R1 final idle", {ale, oe_n, bus_oe, busy}, 4'b1100);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule